// File: doc/BRIEF.md
# Sideband Byte-Lane Write Gate

This block sits between a host write port and a small bank of 32-bit registers. The byte lanes that a data write may touch do not come from bus strobes. They come from a separate lane control register, which the host writes just before the data write. A data write then changes only the bytes of the addressed word whose lane enable is set, and the other bytes keep their value.

The lane control register shares the word address space with the register bank and sits on the index just above the last bank word. Its bits 6:3 are the four lane enables, and bit 3 controls byte 0 (data bits 7:0). The enables stay in force until the control register is written again.

A combinational helper turns an access size and a byte offset into the control value the host should write first. The host writes that value to the control register, then issues the data write on the very next cycle. The whole control word and the register bank can be read back through a combinational read port.

Top module: `byte_lane_gate`

## Requirements
- R1: After reset the control register reads 0x78 (bits 6:3 set, all other bits clear), all four lane enables are on, and every bank word reads zero.
- R2: A write to the control index (NUM_REGS) stores wr_data[7:0]. Reading that index returns the stored byte in bits 7:0 and zero above.
- R3: lane_en[i] equals control bit 3+i, for i = 0..3.
- R4: A write to a bank index below NUM_REGS replaces byte i (data bits 8i+7:8i) of the addressed word only when lane_en[i] is 1. Bytes with a clear enable keep their old value.
- R5: The lane enables keep their value until the control register is written again, across any number of data writes.
- R6: A write to the control register leaves every bank word unchanged.
- R7: Writes to indices above NUM_REGS change neither the bank nor the control register, and reads of those indices return zero.
- R8: For req_size 2 (word) the helper outputs 0xF8. For req_size 3 (reserved) it outputs 0x00.
- R9: For req_size 1 (half) the helper outputs ((3 << req_off) << 3), truncated to 8 bits.
- R10: For req_size 0 (byte) the helper outputs ((1 << req_off) << 3), truncated to 8 bits.
- R11: A control write takes effect on a data write issued in the very next clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W (4) | Word index: bank 0..NUM_REGS-1, control at NUM_REGS |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W (4) | Read word index |
| rd_data | output | 32 | Combinational read data |
| lane_en | output | 4 | Current lane enables, bit i for byte i |
| req_size | input | 2 | Helper size: 0 byte, 1 half, 2 word, 3 reserved |
| req_off | input | 2 | Helper byte offset (low address bits) |
| req_ctl | output | 8 | Helper control value to write before the data write |

## Verification
The assertions check on every cycle:
- a control write shows up on lane_en one cycle later;
- lane_en holds steady while no control write occurs;
- the control read view agrees with lane_en;
- unmapped reads return zero;
- the helper outputs have the right shape.

The merge of new and old bytes needs a scenario: preload a word, narrow the lanes, then overwrite. The bench runs this over all sixteen lane patterns and checks the result against a byte-merge model. The same is true for persistence over several data writes, for ignored writes to unmapped indices, and for the exhaustive helper table.

// File: rtl/byte_lane_pkg.sv
package byte_lane_pkg;
    localparam int LANES    = 4;
    localparam int LANE_W   = 8;
    localparam int DATA_W   = LANES * LANE_W;
    localparam int CTL_W    = 8;
    localparam int LANE_LSB = 3;
    localparam logic [CTL_W-1:0] CTL_RESET = CTL_W'(((1 << LANES) - 1) << LANE_LSB);
    localparam logic [CTL_W-1:0] CTL_WORD  = CTL_W'(((1 << (LANES + 1)) - 1) << LANE_LSB);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } access_size_e;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
    } ctl_state_t;
endpackage

// File: rtl/lane_ctl_reg.sv
module lane_ctl_reg
    import byte_lane_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [CTL_W-1:0] ctl_wdata,
    output logic [CTL_W-1:0] ctl_value,
    output logic [LANES-1:0] lane_en
);
    ctl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.ctl = ctl_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl <= CTL_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_value = st_q.ctl;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_en[l] = st_q.ctl[LANE_LSB + l];
    end
endmodule

// File: rtl/lane_derive.sv
module lane_derive
    import byte_lane_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       offset,
    output logic [CTL_W-1:0] ctl_value
);
    logic [CTL_W-1:0] base;
    logic [CTL_W-1:0] shifted;

    always_comb begin
        case (access_size_e'(size))
            SZ_BYTE: base = CTL_W'(1);
            SZ_HALF: base = CTL_W'(3);
            default: base = '0;
        endcase
        shifted = base << offset;
        case (access_size_e'(size))
            SZ_WORD: ctl_value = CTL_WORD;
            SZ_RSVD: ctl_value = '0;
            default: ctl_value = shifted << LANE_LSB;
        endcase
    end
endmodule

// File: rtl/lane_regfile.sv
module lane_regfile
    import byte_lane_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LANES-1:0]  lane_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_word
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] words;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic [DATA_W-1:0] bit_mask;

    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign bit_mask[l*LANE_W +: LANE_W] = {LANE_W{lane_en[l]}};
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && (int'(wr_idx) < NUM_REGS)) begin
            st_d.words[wr_idx] = (st_q.words[wr_idx] & ~bit_mask) | (wr_data & bit_mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_word = '0;
        if (int'(rd_idx) < NUM_REGS) begin
            rd_word = st_q.words[rd_idx];
        end
    end
endmodule

// File: rtl/byte_lane_gate.sv
module byte_lane_gate
    import byte_lane_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [LANES-1:0]  lane_en,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_off,
    output logic [CTL_W-1:0]  req_ctl
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_REGS);

    logic              ctl_we;
    logic              bank_we;
    logic [CTL_W-1:0]  ctl_value;
    logic [DATA_W-1:0] bank_word;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    always_comb begin
        ctl_we  = wr_en && (wr_addr == CTL_ADDR);
        bank_we = wr_en && (wr_addr < CTL_ADDR);
        wr_idx  = IDX_W'(wr_addr);
        rd_idx  = IDX_W'(rd_addr);
    end

    lane_ctl_reg u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (wr_data[CTL_W-1:0]),
        .ctl_value (ctl_value),
        .lane_en   (lane_en)
    );

    lane_regfile #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bank_we),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .lane_en (lane_en),
        .rd_idx  (rd_idx),
        .rd_word (bank_word)
    );

    lane_derive u_derive (
        .size      (req_size),
        .offset    (req_off),
        .ctl_value (req_ctl)
    );

    always_comb begin
        if (rd_addr < CTL_ADDR) begin
            rd_data = bank_word;
        end else if (rd_addr == CTL_ADDR) begin
            rd_data = DATA_W'(ctl_value);
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: rtl/byte_lane_gate_chk.sv
module byte_lane_gate_chk #(
    parameter int NUM_REGS = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [3:0]        wr_lane_bits,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic [3:0]        lane_en,
    input logic [1:0]        req_size,
    input logic [1:0]        req_off,
    input logic [7:0]        req_ctl
);
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_REGS);

    // R2
    ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTL_ADDR) |=> (lane_en == $past(wr_lane_bits)));

    // R5
    lanes_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == CTL_ADDR) |=> $stable(lane_en));

    // R3
    lane_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == CTL_ADDR) |-> (rd_data[6:3] == lane_en));

    // R7
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > CTL_ADDR) |-> (rd_data == 32'd0));

    // R8
    word_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == 2'd2) |-> (req_ctl == 8'hF8));

    // R10
    byte_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == 2'd0) |-> ($countones(req_ctl) == 1 && req_ctl[2:0] == 3'd0));

    // R9
    half_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_size == 2'd1 && req_off != 2'd3) |-> ($countones(req_ctl) == 2 && req_ctl[2:0] == 3'd0));
endmodule

bind byte_lane_gate byte_lane_gate_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_lane_bits (wr_data[6:3]),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .lane_en      (lane_en),
    .req_size     (req_size),
    .req_off      (req_off),
    .req_ctl      (req_ctl)
);

// File: tb/sim_byte_lane_gate.sv
`timescale 1ns/1ps
module sim_byte_lane_gate;
    localparam int NUM_REGS = 8;
    localparam int ADDR_W   = $clog2(NUM_REGS + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0]       rd_data;
    logic [3:0]        lane_en;
    logic [1:0]        req_size = '0;
    logic [1:0]        req_off = '0;
    logic [7:0]        req_ctl;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [31:0] model [NUM_REGS];
    logic [7:0]  model_ctl;

    always #10 clk = ~clk;

    byte_lane_gate #(.NUM_REGS(NUM_REGS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .lane_en(lane_en), .req_size(req_size), .req_off(req_off),
        .req_ctl(req_ctl)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] old_w, input logic [31:0] new_w,
                                          input logic [3:0] lanes);
        logic [31:0] r;
        r = old_w;
        for (int b = 0; b < 4; b++) begin
            if (lanes[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        end
        return r;
    endfunction

    task automatic write1(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // control write followed by a data write on the next cycle (R11)
    task automatic write_pair(input logic [31:0] ctl, input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(NUM_REGS); wr_data = ctl;
        @(negedge clk);
        wr_addr = ADDR_W'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_check(input string tag, input int addr, input logic [31:0] exp);
        rd_addr = ADDR_W'(addr);
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic check_bank(input string tag);
        for (int i = 0; i < NUM_REGS; i++) read_check(tag, i, model[i]);
    endtask

    function automatic logic [3:0] lanes_of(input logic [7:0] c);
        return c[6:3];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_REGS; i++) model[i] = '0;
        model_ctl = 8'h78;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_check("R1 ctl reset", NUM_REGS, 32'h78);
        check("R1 lanes reset", {28'd0, lane_en}, 32'hF);
        check_bank("R1 bank reset");

        // R4 full-lane preload of every word
        for (int i = 0; i < NUM_REGS; i++) begin
            model[i] = 32'h1111_1111 * (i + 1);
            write1(i, model[i]);
        end
        check_bank("R4 full preload");

        // sweep all lane patterns: R2 R3 R4 R5 R6 R11
        for (int m = 0; m < 16; m++) begin
            int k;
            logic [31:0] ctlw, d1, d2;
            k = m % NUM_REGS;
            ctlw = 32'hABCD_0000 | (32'(m) << 3) | ((m % 2 == 1) ? 32'h87 : 32'h05);
            d1 = 32'hC0DE_0000 ^ (32'(m) * 32'h0101_0101) ^ 32'h5A5A_5A5A;
            d2 = ~d1 ^ (32'(m) << 8);
            write_pair(ctlw, k, d1);
            model_ctl = ctlw[7:0];
            model[k] = merge(model[k], d1, lanes_of(model_ctl));
            read_check("R2 ctl readback", NUM_REGS, {24'd0, model_ctl});
            check("R3 lane_en", {28'd0, lane_en}, {28'd0, lanes_of(model_ctl)});
            read_check("R4 R11 merged word", k, model[k]);
            write1((k + 3) % NUM_REGS, d2);
            model[(k + 3) % NUM_REGS] = merge(model[(k + 3) % NUM_REGS], d2, lanes_of(model_ctl));
            check("R5 lanes persist", {28'd0, lane_en}, {28'd0, lanes_of(model_ctl)});
            read_check("R5 second write", (k + 3) % NUM_REGS, model[(k + 3) % NUM_REGS]);
            // R6 control-only write leaves bank alone
            write1(NUM_REGS, 32'h0000_0078);
            model_ctl = 8'h78;
            check_bank("R6 bank after ctl write");
        end

        // R7 unmapped writes and reads
        for (int a = NUM_REGS + 1; a < (1 << ADDR_W); a++) begin
            write1(a, 32'hDEAD_BEEF);
            read_check("R7 unmapped read", a, 32'd0);
        end
        check_bank("R7 bank untouched");
        read_check("R7 ctl untouched", NUM_REGS, {24'd0, model_ctl});

        // R8 R9 R10 helper table, exhaustive
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 4; o++) begin
                logic [7:0] e;
                if (s == 0) e = 8'(8'(1 << o) << 3);
                else if (s == 1) e = 8'(8'(3 << o) << 3);
                else if (s == 2) e = 8'hF8;
                else e = 8'h00;
                @(negedge clk);
                req_size = 2'(s); req_off = 2'(o);
                #1;
                case (s)
                    0: check("R10 byte helper", {24'd0, req_ctl}, {24'd0, e});
                    1: check("R9 half helper", {24'd0, req_ctl}, {24'd0, e});
                    default: check("R8 word/rsvd helper", {24'd0, req_ctl}, {24'd0, e});
                endcase
            end
        end

        // R11 helper-driven halfword write at offset 2, then byte at offset 1
        req_size = 2'd1; req_off = 2'd2; #1;
        write_pair({24'd0, req_ctl}, 1, 32'h9876_5432);
        model[1] = merge(model[1], 32'h9876_5432, 4'b1100);
        read_check("R11 half via helper", 1, model[1]);
        req_size = 2'd0; req_off = 2'd1; #1;
        write_pair({24'd0, req_ctl}, 1, 32'h0000_EE00);
        model[1] = merge(model[1], 32'h0000_EE00, 4'b0010);
        read_check("R11 byte via helper", 1, model[1]);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule